// File: doc/BRIEF.md
# Endpoint Buffer Flush Controller

This block belongs to a USB device-mode controller. It lets software cancel buffers that have been primed for the transmit and receive sides of three endpoints. Software writes ones to a flush register. For each marked endpoint and direction, the block clears the primed-buffer state that the transfer engine relies on. A flush bit stays set until its flush has finished, and then hardware clears it. If a packet is in flight on that endpoint and direction, the flush waits for the packet to end.

The transfer engine sends a one-cycle prime pulse whenever it arms a buffer. It also holds a busy level for as long as a packet is moving. The block returns the resulting ready state to the engine and shows it in a read-only register. No data streams through this block, so it has no valid/ready interface. All pins are plain control and status levels or pulses. The register port is a single-cycle write strobe with a combinational read of the addressed word.

Top module: `epf_ctrl`

## Requirements
- R1: After reset, the flush register (offset 0x1B4) and the ready register (offset 0x1B8) both read zero. Reserved bits always read zero, and any other offset reads zero.
- R2: A write to 0x1B4 with bit 16+n set starts a transmit flush of endpoint n. With bit n set it starts a receive flush of endpoint n, for n from 0 to 2. The flush bit reads one in the cycle after the write. Zero bits in the written word leave their flush bits unchanged.
- R3: A prime pulse on an endpoint and direction sets its ready bit from the next cycle. Transmit ready bits are at 16+n of 0x1B8 and receive ready bits are at n.
- R4: While an endpoint and direction has a flush pending and its busy input is high, both its flush bit and its ready bit keep their values.
- R5: A pending flush completes at the clock edge that ends the first cycle in which its busy input is low. A flush written while busy is low therefore reads one for exactly one cycle.
- R6: The edge that completes a flush clears that endpoint and direction's ready bit, and hardware clears the flush bit at the same edge.
- R7: If a prime pulse arrives in the same cycle that a flush completes, the prime takes effect after the flush, so the ready bit ends at one.
- R8: Writing one again to a flush bit that is still pending keeps it pending. The flush still completes on the edge after busy goes low.
- R9: When host_mode is high, register writes are ignored and no flush starts.
- R10: The six endpoint and direction lanes are independent. Flushes, busy levels and primes on one lane never change another lane's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | High when the controller is in host mode; blocks register writes |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_prime | input | 3 | Per-endpoint transmit prime pulse |
| rx_prime | input | 3 | Per-endpoint receive prime pulse |
| tx_busy | input | 3 | Per-endpoint transmit packet in progress |
| rx_busy | input | 3 | Per-endpoint receive packet in progress |
| tx_ready | output | 3 | Per-endpoint transmit primed state |
| rx_ready | output | 3 | Per-endpoint receive primed state |

## Verification
Every result is one register stage from its cause. A flush bit reads one in the cycle after its write edge. It clears at the edge that ends its first busy-low cycle, which is one cycle after the write at the earliest. A ready bit changes at the edge after a prime pulse or a completing flush. The bench drives inputs on falling edges and reads the combinational read port just after falling edges. It sweeps all 64 flush patterns against several busy masks. It reads both registers after the write edge, after the completion edge for idle lanes, and after busy is released. The expected words come from bitwise arithmetic on the pattern and the mask.

// File: rtl/epf_pkg.sv
package epf_pkg;
  localparam int EP_CNT = 3;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int TX_POS = 16;
  localparam int RX_POS = 0;
  localparam logic [ADDR_W-1:0] FLUSH_OFS = 12'h1B4;
  localparam logic [ADDR_W-1:0] READY_OFS = 12'h1B8;

  typedef logic [EP_CNT-1:0] ep_vec_t;

  function automatic logic [DATA_W-1:0] place_fields(ep_vec_t tx, ep_vec_t rx);
    logic [DATA_W-1:0] w;
    w = '0;
    w[TX_POS +: EP_CNT] = tx;
    w[RX_POS +: EP_CNT] = rx;
    return w;
  endfunction
endpackage

// File: rtl/epf_lane.sv
module epf_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic prime_set,
  input  logic busy,
  output logic pend_o,
  output logic ready_o
);
  logic pend_q, ready_q, finish;

  assign finish = pend_q & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      pend_q  <= req_set | (pend_q & busy);
      ready_q <= prime_set | (ready_q & ~finish);
    end
  end

  assign pend_o  = pend_q;
  assign ready_o = ready_q;

  AST_PEND_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && busy) |=> pend_o); // R4
  AST_READY_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && busy && ready_o) |=> ready_o); // R4
  AST_FLUSH_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !busy && !req_set) |=> !pend_o); // R5
  AST_FLUSH_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !busy && !prime_set) |=> !ready_o); // R6
  AST_PRIME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    prime_set |=> ready_o); // R7
  AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_set |=> pend_o); // R2
endmodule

// File: rtl/epf_regs.sv
module epf_regs
  import epf_pkg::*;
(
  input  logic              host_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  ep_vec_t           tx_pend,
  input  ep_vec_t           rx_pend,
  input  ep_vec_t           tx_rdy,
  input  ep_vec_t           rx_rdy,
  output ep_vec_t           tx_req,
  output ep_vec_t           rx_req,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] USED_MASK = place_fields('1, '1);

  logic flush_wr;
  logic unused_wbits;

  assign flush_wr = wr_en & ~host_mode & (addr == FLUSH_OFS);
  assign tx_req   = flush_wr ? wdata[TX_POS +: EP_CNT] : '0;
  assign rx_req   = flush_wr ? wdata[RX_POS +: EP_CNT] : '0;
  assign unused_wbits = ^(wdata & ~USED_MASK);

  always_comb begin
    unique case (addr)
      FLUSH_OFS: rdata = place_fields(tx_pend, rx_pend);
      READY_OFS: rdata = place_fields(tx_rdy, rx_rdy);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/epf_ctrl.sv
module epf_ctrl
  import epf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EP_CNT-1:0] tx_prime,
  input  logic [EP_CNT-1:0] rx_prime,
  input  logic [EP_CNT-1:0] tx_busy,
  input  logic [EP_CNT-1:0] rx_busy,
  output logic [EP_CNT-1:0] tx_ready,
  output logic [EP_CNT-1:0] rx_ready
);
  ep_vec_t tx_req, rx_req, tx_pend, rx_pend;

  epf_regs u_regs (
    .host_mode (host_mode),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .tx_pend   (tx_pend),
    .rx_pend   (rx_pend),
    .tx_rdy    (tx_ready),
    .rx_rdy    (rx_ready),
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .rdata     (reg_rdata)
  );

  for (genvar e = 0; e < EP_CNT; e++) begin : g_ep
    epf_lane u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_set   (tx_req[e]),
      .prime_set (tx_prime[e]),
      .busy      (tx_busy[e]),
      .pend_o    (tx_pend[e]),
      .ready_o   (tx_ready[e])
    );
    epf_lane u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_set   (rx_req[e]),
      .prime_set (rx_prime[e]),
      .busy      (rx_busy[e]),
      .pend_o    (rx_pend[e]),
      .ready_o   (rx_ready[e])
    );
  end

  AST_HOST_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && tx_pend == '0 && rx_pend == '0) |=> (tx_pend == '0 && rx_pend == '0)); // R9
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && tx_pend == '0) |=> tx_pend == '0); // R10
endmodule

// File: tb/test_epf_ctrl.sv
`timescale 1ns/1ps
module test_epf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  tx_prime = '0, rx_prime = '0, tx_busy = '0, rx_busy = '0;
  logic [2:0]  tx_ready, rx_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_FLUSH = 12'h1B4;
  localparam logic [11:0] A_READY = 12'h1B8;

  always #2.5 clk = ~clk;

  epf_ctrl i_epf_ctrl (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_prime(tx_prime), .rx_prime(rx_prime), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .tx_ready(tx_ready), .rx_ready(rx_ready)
  );

  // lane vector bits [5:3] = tx ep2..0, [2:0] = rx ep2..0
  function automatic logic [31:0] to_word(logic [5:0] v);
    return {13'b0, v[5:3], 13'b0, v[2:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic set_busy(logic [5:0] b);
    tx_busy = b[5:3]; rx_busy = b[2:0];
  endtask

  task automatic prime_all();
    @(negedge clk);
    tx_prime = '1; rx_prime = '1;
    @(negedge clk);
    tx_prime = '0; rx_prime = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and reserved/unknown offsets
    rd_chk("R1", A_FLUSH, 32'h0);
    rd_chk("R1", A_READY, 32'h0);
    rd_chk("R1", 12'h1B0, 32'h0);

    // R3 prime sets ready next cycle
    @(negedge clk); tx_prime = 3'b010; rx_prime = 3'b001;
    @(negedge clk); tx_prime = '0; rx_prime = '0;
    rd_chk("R3", A_READY, to_word(6'b010_001));

    // R2, R4, R5, R6, R10 sweep
    for (int p = 0; p < 64; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [5:0] b;
        logic [5:0] pv;
        pv = p[5:0];
        case (k)
          0: b = 6'h00;
          1: b = 6'h3F;
          2: b = pv ^ 6'h15;
          default: b = 6'h2A;
        endcase
        @(negedge clk); set_busy(b);
        prime_all();
        rd_chk("R3", A_READY, to_word(6'h3F));
        wr(A_FLUSH, to_word(pv) | 32'hFFF8_FFF8 & {32{k[0]}} & 32'h0);
        rd_chk("R2", A_FLUSH, to_word(pv));
        rd_chk("R4", A_READY, to_word(6'h3F));
        @(negedge clk);
        rd_chk("R5", A_FLUSH, to_word(pv & b));
        rd_chk("R6", A_READY, to_word(~(pv & ~b)));
        @(negedge clk);
        rd_chk("R4", A_FLUSH, to_word(pv & b));
        set_busy(6'h00);
        @(negedge clk);
        rd_chk("R5", A_FLUSH, 32'h0);
        rd_chk("R10", A_READY, to_word(~pv));
      end
    end

    // R2 zero bits and reserved bits ignored
    @(negedge clk); set_busy(6'h3F);
    wr(A_FLUSH, 32'hFFF8_FFF8);
    rd_chk("R2", A_FLUSH, 32'h0);
    wr(A_FLUSH, to_word(6'b100_000));
    wr(A_FLUSH, to_word(6'b000_010));
    rd_chk("R2", A_FLUSH, to_word(6'b100_010));

    // R8 rewrite while pending
    wr(A_FLUSH, to_word(6'b100_000));
    rd_chk("R8", A_FLUSH, to_word(6'b100_010));
    @(negedge clk); tx_busy = 3'b011;
    @(negedge clk);
    rd_chk("R8", A_FLUSH, to_word(6'b000_010));
    set_busy(6'h00);
    @(negedge clk);
    rd_chk("R8", A_FLUSH, 32'h0);

    // R7 prime in completion cycle
    prime_all();
    @(negedge clk); set_busy(6'b000_100);
    wr(A_FLUSH, to_word(6'b000_100));
    rx_busy = 3'b000; rx_prime = 3'b100;
    @(negedge clk); rx_prime = '0;
    rd_chk("R7", A_FLUSH, 32'h0);
    rd_chk("R7", A_READY, to_word(6'h3F));

    // R9 host mode blocks writes
    @(negedge clk); host_mode = 1'b1; set_busy(6'h3F);
    wr(A_FLUSH, to_word(6'h3F));
    rd_chk("R9", A_FLUSH, 32'h0);
    @(negedge clk);
    rd_chk("R9", A_READY, to_word(6'h3F));
    host_mode = 1'b0; set_busy(6'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule